// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular reorder buffer for an out-of-order core. Instructions are entered one per cycle, in program order, at the tail slot. Each slot's index is the instruction's tag. Execution units report finished results over two broadcast lanes, each carrying a tag and a value. A broadcast marks the matching slot as finished and stores its value. The same broadcast is compared against every source operand that is still waiting. A matching operand captures the value, and the match is signalled on a per-slot wake vector in that same cycle.

Retirement reads the oldest slots. Up to two finished slots leave per cycle, always oldest first. Retirement stops at the first slot that has not finished, so results reach the register file in program order even when execution finishes out of order. A slot reports that it can issue once every operand it holds is available and it has not yet finished. An operand read port lets an issue stage fetch the captured operand values of any slot.

Each head and tail pointer carries one bit above the index. Equal indices with equal extra bits mean empty; equal indices with different extra bits mean full.

Top module: `rob_inorder_commit`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `alloc_ready`=1, `commit_valid`=0, `ready_vec`=0, and the first accepted allocation receives tag 0.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both 1. `alloc_tag` shows the tail slot index before the edge, and successive accepted allocations receive tags 0,1,...,DEPTH-1,0,... in order.
- R3: `alloc_ready` is 0 while DEPTH slots are occupied. An `alloc_valid` pulse while `alloc_ready`=0 changes no slot and does not advance the tail.
- R4: A broadcast on lane p (`cmp_valid[p]`, tag in `cmp_tag[p*TAG_W +: TAG_W]`, value in `cmp_val[p*DATA_W +: DATA_W]`) marks an occupied, unfinished slot as finished and stores the value. A broadcast to an empty slot, or to a slot that has already finished, is ignored. Both lanes may be used in one cycle.
- R5: Retirement starts at the head and never passes a slot that has not finished. A slot finished by a broadcast is retired from the cycle after that broadcast.
- R6: At most two slots retire per cycle. Lane 0 (`commit_valid[0]`, `commit_dest[4:0]`, `commit_val[15:0]`) carries the oldest slot. Lane 1 (upper fields) carries the next slot and is valid only together with lane 0.
- R7: In the cycle of a broadcast, `wake_vec[i]` is 1 when slot i holds a waiting operand whose tag equals a broadcast tag.
- R8: A waiting operand captures the broadcast value. From the next cycle, `ready_vec[i]` is 1 when slot i is occupied, unfinished, and all of its operands are available.
- R9: At allocation, operand s with `alloc_src_rob[s]`=0 is available with value `alloc_src_val[s*DATA_W +: DATA_W]`. With `alloc_src_rob[s]`=1 it names tag `alloc_src_tag[s*TAG_W +: TAG_W]`. It takes the stored value if that slot has finished, or the broadcast value if that tag is broadcast in the same cycle; otherwise it waits.
- R10: `rd_opnd` shows the operand values held by slot `rd_idx` without a clock delay, operand s at bits [s*DATA_W +: DATA_W].
- R11: `empty` is 1 exactly when no slot is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to enter an instruction |
| alloc_ready | output | 1 | Buffer can accept an instruction |
| alloc_tag | output | TAG_W | Tag the next accepted instruction receives |
| alloc_dest | input | DEST_W | Destination register of the new instruction |
| alloc_src_rob | input | NSRC | Per operand: 1 = value comes from a buffer slot |
| alloc_src_tag | input | NSRC*TAG_W | Per operand producer tag |
| alloc_src_val | input | NSRC*DATA_W | Per operand value when already known |
| cmp_valid | input | NCMP | Broadcast lane valid |
| cmp_tag | input | NCMP*TAG_W | Broadcast lane tag |
| cmp_val | input | NCMP*DATA_W | Broadcast lane result |
| commit_valid | output | NRET | Retire lane valid |
| commit_dest | output | NRET*DEST_W | Retire lane destination |
| commit_val | output | NRET*DATA_W | Retire lane result |
| wake_vec | output | DEPTH | Same-cycle operand match per slot |
| ready_vec | output | DEPTH | Slot can issue |
| rd_idx | input | TAG_W | Slot whose operands are read |
| rd_opnd | output | NSRC*DATA_W | Operand values of slot rd_idx |
| empty | output | 1 | No slot occupied |

## Verification
Broadcasts, allocations and retirements take effect at the edge. The retire lanes, `alloc_ready`, `empty` and `ready_vec` therefore change one cycle after the stimulus that causes them. `wake_vec`, `alloc_tag` and `rd_opnd` follow their inputs in the same cycle. The bench drives on the falling edge. It reads registered results at the next falling edge, before it applies new stimulus, and it reads same-cycle results one time step after driving. A reference queue in the bench advances once per cycle in the same order, so every expected retirement is fixed before the edge that produces it.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic {
    SRC_WAIT = 1'b0,
    SRC_HAVE = 1'b1
  } src_state_e;

  // Distance from head to tail on pointers of ptr_w bits.
  function automatic int unsigned wrap_distance(int unsigned head,
                                                int unsigned tail,
                                                int unsigned ptr_w);
    int unsigned mask;
    mask = (32'd1 << ptr_w) - 32'd1;
    return (tail - head) & mask;
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl import rob_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int NRET  = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1,
  localparam int CNT_W = $clog2(NRET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [CNT_W-1:0] ret_cnt,
  output logic [TAG_W-1:0] head_idx,
  output logic [TAG_W-1:0] tail_idx,
  output logic [PTR_W-1:0] occ,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] head_q, tail_q;

  function automatic logic ptr_full(logic [PTR_W-1:0] h, logic [PTR_W-1:0] t);
    return (h[TAG_W-1:0] == t[TAG_W-1:0]) && (h[TAG_W] != t[TAG_W]);
  endfunction

  function automatic logic ptr_empty(logic [PTR_W-1:0] h, logic [PTR_W-1:0] t);
    return h == t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc_fire) tail_q <= tail_q + PTR_W'(1);
      head_q <= head_q + PTR_W'(ret_cnt);
    end
  end

  assign head_idx = head_q[TAG_W-1:0];
  assign tail_idx = tail_q[TAG_W-1:0];
  assign occ      = PTR_W'(wrap_distance(32'(head_q), 32'(tail_q), PTR_W));
  assign full     = ptr_full(head_q, tail_q);
  assign empty    = ptr_empty(head_q, tail_q);

endmodule

// File: rtl/rob_slot.sv
module rob_slot import rob_pkg::*; #(
  parameter int TAG_W   = 3,
  parameter int DATA_W  = 16,
  parameter int DEST_W  = 5,
  parameter int NSRC    = 2,
  parameter int NCMP    = 2,
  parameter int SLOT_ID = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_hit,
  input  logic [DEST_W-1:0]      alloc_dest,
  input  logic [NSRC-1:0]        alloc_have,
  input  logic [NSRC*TAG_W-1:0]  alloc_tag,
  input  logic [NSRC*DATA_W-1:0] alloc_val,
  input  logic [NCMP-1:0]        cmp_valid,
  input  logic [NCMP*TAG_W-1:0]  cmp_tag,
  input  logic [NCMP*DATA_W-1:0] cmp_val,
  input  logic                   retire_hit,
  output logic                   valid_o,
  output logic                   done_o,
  output logic [DEST_W-1:0]      dest_o,
  output logic [DATA_W-1:0]      value_o,
  output logic                   ready_o,
  output logic                   wake_o,
  output logic [NSRC*DATA_W-1:0] opnd_o
);

  localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(SLOT_ID);

  logic              valid_q, done_q;
  logic [DEST_W-1:0] dest_q;
  logic [DATA_W-1:0] value_q;
  src_state_e        src_state_q [NSRC];
  logic [TAG_W-1:0]  src_tag_q   [NSRC];
  logic [DATA_W-1:0] src_val_q   [NSRC];

  logic              self_hit;
  logic [DATA_W-1:0] self_val;
  logic [NSRC-1:0]   src_hit;
  logic [NSRC-1:0]   src_wait;
  logic [DATA_W-1:0] src_bval [NSRC];
  logic              all_have;

  // Own completion: lowest lane wins if two lanes carry the same tag.
  always_comb begin
    self_hit = 1'b0;
    self_val = '0;
    for (int p = NCMP - 1; p >= 0; p--) begin
      if (cmp_valid[p] && (cmp_tag[p*TAG_W +: TAG_W] == MY_TAG)) begin
        self_hit = 1'b1;
        self_val = cmp_val[p*DATA_W +: DATA_W];
      end
    end
  end

  // Operand wakeup compare against every broadcast lane.
  always_comb begin
    all_have = 1'b1;
    for (int s = 0; s < NSRC; s++) begin
      src_hit[s]  = 1'b0;
      src_bval[s] = '0;
      src_wait[s] = (src_state_q[s] == SRC_WAIT);
      if (src_wait[s]) all_have = 1'b0;
      for (int p = NCMP - 1; p >= 0; p--) begin
        if (cmp_valid[p] && (cmp_tag[p*TAG_W +: TAG_W] == src_tag_q[s])) begin
          src_hit[s]  = 1'b1;
          src_bval[s] = cmp_val[p*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      dest_q  <= '0;
      value_q <= '0;
      for (int s = 0; s < NSRC; s++) begin
        src_state_q[s] <= SRC_HAVE;
        src_tag_q[s]   <= '0;
        src_val_q[s]   <= '0;
      end
    end else if (alloc_hit) begin
      valid_q <= 1'b1;
      done_q  <= 1'b0;
      dest_q  <= alloc_dest;
      value_q <= '0;
      for (int s = 0; s < NSRC; s++) begin
        src_state_q[s] <= alloc_have[s] ? SRC_HAVE : SRC_WAIT;
        src_tag_q[s]   <= alloc_tag[s*TAG_W +: TAG_W];
        src_val_q[s]   <= alloc_val[s*DATA_W +: DATA_W];
      end
    end else begin
      if (retire_hit) valid_q <= 1'b0;
      if (valid_q && !done_q && self_hit) begin
        done_q  <= 1'b1;
        value_q <= self_val;
      end
      for (int s = 0; s < NSRC; s++) begin
        if (valid_q && src_wait[s] && src_hit[s]) begin
          src_state_q[s] <= SRC_HAVE;
          src_val_q[s]   <= src_bval[s];
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NSRC; s++) opnd_o[s*DATA_W +: DATA_W] = src_val_q[s];
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign dest_o  = dest_q;
  assign value_o = value_q;
  assign ready_o = valid_q && !done_q && all_have;
  assign wake_o  = valid_q && |(src_hit & src_wait);

endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick #(
  parameter int DEPTH  = 8,
  parameter int NRET   = 2,
  parameter int DATA_W = 16,
  parameter int DEST_W = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(NRET + 1)
) (
  input  logic [TAG_W-1:0]        head_idx,
  input  logic [DEPTH-1:0]        valid_vec,
  input  logic [DEPTH-1:0]        done_vec,
  input  logic [DEPTH*DEST_W-1:0] dest_flat,
  input  logic [DEPTH*DATA_W-1:0] value_flat,
  output logic [NRET-1:0]         commit_valid,
  output logic [NRET*DEST_W-1:0]  commit_dest,
  output logic [NRET*DATA_W-1:0]  commit_val,
  output logic [CNT_W-1:0]        ret_cnt,
  output logic [DEPTH-1:0]        retire_vec
);

  // Lane k retires slot head+k only if every older lane also retires.
  always_comb begin
    logic             chain;
    logic             ok;
    logic [TAG_W-1:0] idx;
    chain        = 1'b1;
    ret_cnt      = '0;
    retire_vec   = '0;
    commit_valid = '0;
    commit_dest  = '0;
    commit_val   = '0;
    for (int k = 0; k < NRET; k++) begin
      idx = head_idx + TAG_W'(k);
      ok  = chain && valid_vec[idx] && done_vec[idx];
      commit_valid[k] = ok;
      if (ok) begin
        commit_dest[k*DEST_W +: DEST_W] = dest_flat[idx*DEST_W +: DEST_W];
        commit_val[k*DATA_W +: DATA_W]  = value_flat[idx*DATA_W +: DATA_W];
        retire_vec[idx] = 1'b1;
        ret_cnt = ret_cnt + CNT_W'(1);
      end
      chain = ok;
    end
  end

endmodule

// File: rtl/rob_inorder_commit.sv
module rob_inorder_commit import rob_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int DEST_W = 5,
  parameter int NSRC   = 2,
  parameter int NCMP   = 2,
  parameter int NRET   = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1,
  localparam int CNT_W = $clog2(NRET + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_valid,
  output logic                   alloc_ready,
  output logic [TAG_W-1:0]       alloc_tag,
  input  logic [DEST_W-1:0]      alloc_dest,
  input  logic [NSRC-1:0]        alloc_src_rob,
  input  logic [NSRC*TAG_W-1:0]  alloc_src_tag,
  input  logic [NSRC*DATA_W-1:0] alloc_src_val,
  input  logic [NCMP-1:0]        cmp_valid,
  input  logic [NCMP*TAG_W-1:0]  cmp_tag,
  input  logic [NCMP*DATA_W-1:0] cmp_val,
  output logic [NRET-1:0]        commit_valid,
  output logic [NRET*DEST_W-1:0] commit_dest,
  output logic [NRET*DATA_W-1:0] commit_val,
  output logic [DEPTH-1:0]       wake_vec,
  output logic [DEPTH-1:0]       ready_vec,
  input  logic [TAG_W-1:0]       rd_idx,
  output logic [NSRC*DATA_W-1:0] rd_opnd,
  output logic                   empty
);

  logic [TAG_W-1:0]             head_idx, tail_idx;
  logic [PTR_W-1:0]             occ;
  logic                         full;
  logic                         alloc_fire;
  logic [CNT_W-1:0]             ret_cnt;
  logic [DEPTH-1:0]             retire_vec;
  logic [DEPTH-1:0]             valid_vec, done_vec;
  logic [DEPTH*DEST_W-1:0]      dest_flat;
  logic [DEPTH*DATA_W-1:0]      value_flat;
  logic [DEPTH*NSRC*DATA_W-1:0] opnd_flat;
  logic [NSRC-1:0]              res_have;
  logic [NSRC*DATA_W-1:0]       res_val;

  assign alloc_ready = !full;
  assign alloc_fire  = alloc_valid && !full;
  assign alloc_tag   = tail_idx;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .NRET(NRET)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .ret_cnt    (ret_cnt),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .occ        (occ),
    .full       (full),
    .empty      (empty)
  );

  // Source resolution at allocation: known value, finished producer,
  // or producer broadcasting in this very cycle.
  always_comb begin
    logic [TAG_W-1:0] t;
    for (int s = 0; s < NSRC; s++) begin
      t = alloc_src_tag[s*TAG_W +: TAG_W];
      res_have[s] = 1'b1;
      res_val[s*DATA_W +: DATA_W] = alloc_src_val[s*DATA_W +: DATA_W];
      if (alloc_src_rob[s]) begin
        res_have[s] = valid_vec[t] && done_vec[t];
        res_val[s*DATA_W +: DATA_W] = value_flat[t*DATA_W +: DATA_W];
        for (int p = NCMP - 1; p >= 0; p--) begin
          if (cmp_valid[p] && (cmp_tag[p*TAG_W +: TAG_W] == t)) begin
            res_have[s] = 1'b1;
            res_val[s*DATA_W +: DATA_W] = cmp_val[p*DATA_W +: DATA_W];
          end
        end
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rob_slot #(
      .TAG_W(TAG_W), .DATA_W(DATA_W), .DEST_W(DEST_W),
      .NSRC(NSRC), .NCMP(NCMP), .SLOT_ID(i)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_hit  (alloc_fire && (tail_idx == TAG_W'(i))),
      .alloc_dest (alloc_dest),
      .alloc_have (res_have),
      .alloc_tag  (alloc_src_tag),
      .alloc_val  (res_val),
      .cmp_valid  (cmp_valid),
      .cmp_tag    (cmp_tag),
      .cmp_val    (cmp_val),
      .retire_hit (retire_vec[i]),
      .valid_o    (valid_vec[i]),
      .done_o     (done_vec[i]),
      .dest_o     (dest_flat[i*DEST_W +: DEST_W]),
      .value_o    (value_flat[i*DATA_W +: DATA_W]),
      .ready_o    (ready_vec[i]),
      .wake_o     (wake_vec[i]),
      .opnd_o     (opnd_flat[i*NSRC*DATA_W +: NSRC*DATA_W])
    );
  end

  rob_retire_pick #(
    .DEPTH(DEPTH), .NRET(NRET), .DATA_W(DATA_W), .DEST_W(DEST_W)
  ) u_pick (
    .head_idx     (head_idx),
    .valid_vec    (valid_vec),
    .done_vec     (done_vec),
    .dest_flat    (dest_flat),
    .value_flat   (value_flat),
    .commit_valid (commit_valid),
    .commit_dest  (commit_dest),
    .commit_val   (commit_val),
    .ret_cnt      (ret_cnt),
    .retire_vec   (retire_vec)
  );

  assign rd_opnd = opnd_flat[rd_idx*NSRC*DATA_W +: NSRC*DATA_W];

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 8,
  parameter int NCMP  = 2,
  parameter int NRET  = 2,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             empty,
  input logic [NRET-1:0]  commit_valid,
  input logic [DEPTH-1:0] valid_vec,
  input logic [DEPTH-1:0] wake_vec,
  input logic [NCMP-1:0]  cmp_valid,
  input logic [PTR_W-1:0] occ
);

  // R3: no acceptance while every slot is occupied
  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == PTR_W'(DEPTH)) |-> !alloc_ready);

  // R3: a refused request cannot grow occupancy
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> (occ <= $past(occ)));

  // R2: pointer distance agrees with occupied slots
  assert_occ_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valid_vec) == int'(occ)));

  // R2: an accepted allocation leaves the buffer non-empty
  assert_alloc_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> !empty);

  // R5: nothing retires from an empty buffer
  assert_commit_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid[0] |-> !empty);

  // R11: empty flag agrees with slot occupancy
  assert_empty_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (valid_vec == '0));

  // R7: a wake needs a broadcast in the same cycle
  assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vec != '0) |-> (cmp_valid != '0));

  if (NRET > 1) begin : g_lane
    // R6: a younger lane never retires without the older one
    assert_lane_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid[1] |-> commit_valid[0]);
  end

endmodule

bind rob_inorder_commit rob_checker #(
  .DEPTH(DEPTH), .NCMP(NCMP), .NRET(NRET)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .empty        (empty),
  .commit_valid (commit_valid),
  .valid_vec    (valid_vec),
  .wake_vec     (wake_vec),
  .cmp_valid    (cmp_valid),
  .occ          (occ)
);

// File: tb/tb_rob_inorder_commit.sv
module tb_rob_inorder_commit;

  localparam int DEPTH = 8, DATA_W = 16, DEST_W = 5, NSRC = 2, NCMP = 2, NRET = 2;
  localparam int TAG_W = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_n;
  logic                   alloc_valid, alloc_ready;
  logic [TAG_W-1:0]       alloc_tag;
  logic [DEST_W-1:0]      alloc_dest;
  logic [NSRC-1:0]        alloc_src_rob;
  logic [NSRC*TAG_W-1:0]  alloc_src_tag;
  logic [NSRC*DATA_W-1:0] alloc_src_val;
  logic [NCMP-1:0]        cmp_valid;
  logic [NCMP*TAG_W-1:0]  cmp_tag;
  logic [NCMP*DATA_W-1:0] cmp_val;
  logic [NRET-1:0]        commit_valid;
  logic [NRET*DEST_W-1:0] commit_dest;
  logic [NRET*DATA_W-1:0] commit_val;
  logic [DEPTH-1:0]       wake_vec, ready_vec;
  logic [TAG_W-1:0]       rd_idx;
  logic [NSRC*DATA_W-1:0] rd_opnd;
  logic                   empty;

  rob_inorder_commit dut (.*);

  int n_checks = 0;
  int n_err    = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog run did not end actual=1 expected=0");
    summary();
  end

  task automatic idle();
    alloc_valid = 0; alloc_dest = '0; alloc_src_rob = '0;
    alloc_src_tag = '0; alloc_src_val = '0;
    cmp_valid = '0; cmp_tag = '0; cmp_val = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic put_alloc(int dest, bit r0, int t0, int v0, bit r1, int t1, int v1);
    alloc_valid = 1;
    alloc_dest = DEST_W'(dest);
    alloc_src_rob = {r1, r0};
    alloc_src_tag = {TAG_W'(t1), TAG_W'(t0)};
    alloc_src_val = {DATA_W'(v1), DATA_W'(v0)};
  endtask

  task automatic put_cmp(int lane, int tag, int val);
    cmp_valid[lane] = 1'b1;
    cmp_tag[lane*TAG_W +: TAG_W] = TAG_W'(tag);
    cmp_val[lane*DATA_W +: DATA_W] = DATA_W'(val);
  endtask

  // ---------------- reference queue ----------------
  bit m_valid [DEPTH];
  bit m_done  [DEPTH];
  int m_val   [DEPTH];
  int m_dest  [DEPTH];
  int m_head, m_tail;

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = 0; m_done[i] = 0; m_val[i] = 0; m_dest[i] = 0;
    end
    m_head = 0; m_tail = 0;
  endtask

  task automatic model_check();
    bit chain = 1;
    for (int k = 0; k < NRET; k++) begin
      int idx = (m_head + k) % DEPTH;
      bit ok = chain && m_valid[idx] && m_done[idx];
      chk("R5/R6", $sformatf("lane %0d valid", k), commit_valid[k], ok);
      if (ok) begin
        chk("R6", $sformatf("lane %0d dest", k), commit_dest[k*DEST_W +: DEST_W], m_dest[idx]);
        chk("R4", $sformatf("lane %0d value", k), commit_val[k*DATA_W +: DATA_W], m_val[idx]);
      end
      chain = ok;
    end
    chk("R3", "alloc_ready", alloc_ready, (m_tail - m_head) < DEPTH);
    chk("R11", "empty", empty, m_tail == m_head);
  endtask

  // Advance the queue across one edge, all from pre-edge state.
  task automatic model_step(bit av, int dest, bit c0v, int c0t, int c0d,
                            bit c1v, int c1t, int c1d);
    int  rcnt = 0;
    bit  chain = 1;
    bit  afire = av && ((m_tail - m_head) < DEPTH);
    int  ridx [NRET];
    for (int k = 0; k < NRET; k++) begin
      int idx = (m_head + k) % DEPTH;
      if (chain && m_valid[idx] && m_done[idx]) begin ridx[rcnt] = idx; rcnt++; end
      else chain = 0;
    end
    if (c1v && m_valid[c1t] && !m_done[c1t]) begin m_done[c1t] = 1; m_val[c1t] = c1d; end
    if (c0v && m_valid[c0t] && !m_done[c0t] && !(c1v && c1t == c0t)) begin
      m_done[c0t] = 1; m_val[c0t] = c0d;
    end
    for (int k = 0; k < rcnt; k++) m_valid[ridx[k]] = 0;
    m_head += rcnt;
    if (afire) begin
      int t = m_tail % DEPTH;
      m_valid[t] = 1; m_done[t] = 0; m_dest[t] = dest;
      m_tail++;
    end
  endtask

  typedef struct packed {
    logic        av;
    logic [4:0]  dst;
    logic        c0v;
    logic [2:0]  c0t;
    logic [15:0] c0d;
    logic        c1v;
    logic [2:0]  c1t;
    logic [15:0] c1d;
  } row_t;

  localparam int NROWS = 17;
  localparam row_t TBL [NROWS] = '{
    '{1'b1, 5'd1,  1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 5'd2,  1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 5'd3,  1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 5'd4,  1'b1, 3'd2, 16'h0022, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 5'd5,  1'b1, 3'd1, 16'h0011, 1'b1, 3'd3, 16'h0033},
    '{1'b1, 5'd6,  1'b1, 3'd0, 16'h0010, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 5'd7,  1'b0, 3'd0, 16'h0000, 1'b1, 3'd6, 16'h0066},
    '{1'b1, 5'd8,  1'b1, 3'd4, 16'h0044, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 5'd9,  1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 5'd0,  1'b1, 3'd6, 16'h0666, 1'b1, 3'd5, 16'h0055},
    '{1'b1, 5'd10, 1'b1, 3'd7, 16'h0077, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 5'd0,  1'b1, 3'd0, 16'h0100, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 5'd11, 1'b1, 3'd1, 16'h0101, 1'b1, 3'd0, 16'h0BAD},
    '{1'b0, 5'd0,  1'b1, 3'd2, 16'h0102, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 5'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 5'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 5'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000}
  };

  initial begin
    rd_idx = '0;
    do_reset();

    // R1: reset state
    chk("R1", "empty", empty, 1);
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "commit_valid", commit_valid, 0);
    chk("R1", "ready_vec", ready_vec, 0);
    chk("R1", "alloc_tag", alloc_tag, 0);

    // ---------- table walk against the reference queue (R2 R4 R5 R6) ----------
    model_clear();
    for (int r = 0; r < NROWS; r++) begin
      model_check();
      idle();
      alloc_valid = TBL[r].av;
      alloc_dest  = TBL[r].dst;
      cmp_valid   = {TBL[r].c1v, TBL[r].c0v};
      cmp_tag     = {TBL[r].c1t, TBL[r].c0t};
      cmp_val     = {TBL[r].c1d, TBL[r].c0d};
      #1;
      if (TBL[r].av && alloc_ready)
        chk("R2", "alloc_tag in order", alloc_tag, m_tail % DEPTH);
      model_step(TBL[r].av, int'(TBL[r].dst), TBL[r].c0v, int'(TBL[r].c0t), int'(TBL[r].c0d),
                 TBL[r].c1v, int'(TBL[r].c1t), int'(TBL[r].c1d));
      @(negedge clk);
    end
    model_check();

    // ---------- full buffer, stall, out-of-order finish (R3 R5 R6 R2) ----------
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      put_alloc(20 + i, 0, 0, 0, 0, 0, 0);
      #1;
      chk("R2", "fill tag", alloc_tag, i);
      @(negedge clk);
    end
    idle();
    chk("R3", "ready low when full", alloc_ready, 0);
    put_alloc(31, 0, 0, 0, 0, 0, 0);   // refused request
    @(negedge clk);
    idle();
    chk("R3", "still full after refused request", alloc_ready, 0);
    put_cmp(0, 1, 16'h0A01);           // younger slot finishes first
    @(negedge clk);
    idle();
    chk("R5", "no retire past unfinished head", commit_valid, 0);
    put_cmp(0, 0, 16'h0A00);
    put_cmp(1, 2, 16'h0A02);
    @(negedge clk);
    idle();
    chk("R6", "two lanes retire", commit_valid, 2'b11);
    chk("R6", "lane0 dest", commit_dest[4:0], 20);
    chk("R6", "lane1 dest", commit_dest[9:5], 21);
    chk("R4", "lane0 value", commit_val[15:0], 16'h0A00);
    chk("R4", "lane1 value", commit_val[31:16], 16'h0A01);
    @(negedge clk);
    chk("R5", "stop at unfinished slot", commit_valid, 2'b01);
    chk("R5", "lane0 dest", commit_dest[4:0], 22);
    chk("R3", "ready after retire", alloc_ready, 1);
    put_alloc(30, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R2", "wrapped tag (refused request left tail)", alloc_tag, 0);
    @(negedge clk);
    idle();
    chk("R5", "nothing finished", commit_valid, 0);

    // ---------- operand capture and wakeup (R7 R8 R9 R10) ----------
    do_reset();
    put_alloc(1, 0, 0, 16'h0005, 0, 0, 16'h0006);          // A tag0
    @(negedge clk);
    idle();
    chk("R9", "known operands ready", ready_vec, 8'b0000_0001);
    rd_idx = 0; #1;
    chk("R10", "slot0 operands", rd_opnd, {16'h0006, 16'h0005});
    put_alloc(2, 1, 0, 0, 0, 0, 16'h0007);                 // B tag1 waits on 0
    @(negedge clk);
    idle();
    chk("R9", "waiting operand not ready", ready_vec, 8'b0000_0001);
    put_alloc(3, 1, 0, 0, 1, 1, 0);                        // C tag2 waits 0,1
    @(negedge clk);
    idle();
    chk("R8", "ready before broadcast", ready_vec, 8'b0000_0001);
    put_cmp(0, 0, 16'h00AB);
    #1;
    chk("R7", "same-cycle wake", wake_vec, 8'b0000_0110);
    @(negedge clk);
    idle();
    chk("R8", "ready after capture", ready_vec, 8'b0000_0010);
    rd_idx = 1; #1;
    chk("R8", "captured value", rd_opnd, {16'h0007, 16'h00AB});
    chk("R5", "retire the next cycle", commit_valid, 2'b01);
    chk("R4", "retired value", commit_val[15:0], 16'h00AB);
    put_alloc(4, 1, 1, 0, 0, 0, 16'h0009);                 // D tag3, tag1 broadcast now
    put_cmp(1, 1, 16'h00CD);
    #1;
    chk("R7", "wake on second lane", wake_vec, 8'b0000_0100);
    @(negedge clk);
    idle();
    chk("R9", "broadcast during allocation captured", ready_vec, 8'b0000_1100);
    rd_idx = 3; #1;
    chk("R9", "slot3 operands", rd_opnd, {16'h0009, 16'h00CD});
    rd_idx = 2; #1;
    chk("R10", "slot2 operands", rd_opnd, {16'h00CD, 16'h00AB});
    chk("R6", "lane0 dest", commit_dest[4:0], 2);
    put_alloc(5, 1, 1, 0, 1, 3, 0);                        // E tag4: finished tag1, waits tag3
    @(negedge clk);
    idle();
    rd_idx = 4; #1;
    chk("R9", "value from finished slot", rd_opnd[15:0], 16'h00CD);
    chk("R8", "partly waiting slot not ready", ready_vec, 8'b0000_1100);

    @(negedge clk);
    summary();
  end

endmodule